// File: doc/BRIEF.md
# Critical-Word-First Line Refill Unit

This unit refills one cache line after a read miss. It accepts the missing byte address, fetches the eight 32-bit words of the line from memory one word at a time over a request/response handshake, and collects them in a line buffer. The word the processor was waiting for is sent to the processor in the same cycle that it arrives from memory. The processor can therefore restart before the rest of the line has been fetched. Once all eight words are held, the complete line is written to the cache data array in a single cycle.

A mode bit, sampled when the miss is accepted, selects the fetch order. In wrapping (critical-word-first) mode, the fetch starts at the missed word k and wraps around the line: k, k+1, ..., 7, 0, ..., k-1. In natural-order (early-restart) mode, the fetch always starts at word 0, and the missed word is forwarded when its turn comes. A miss on word 7 in this mode therefore gains nothing: it is forwarded together with the last response. The unit handles one refill at a time and accepts a new miss only while idle.

Top module: `line_refill_unit`

## Requirements
- R1: With `miss_wrap`=1 at acceptance, the first memory request is for the missed word k = `miss_addr[4:2]`. Request n (n = 0..7) is for word (k+n) mod 8.
- R2: With `miss_wrap`=0 at acceptance, request n is for word n, whatever k is.
- R3: In the cycle where `mem_rsp_valid` carries word k, `cpu_valid` is 1 and `cpu_data` equals `mem_rsp_data`. In every other cycle `cpu_valid` is 0.
- R4: `cpu_valid` is high for exactly one cycle per refill. In natural-order mode with k=7, that cycle is the one with the eighth response.
- R5: One cycle after the eighth response is taken, `line_wr_valid` is high for one cycle. `line_wr_data[32*i+31:32*i]` then holds word i of the line, and `line_wr_addr` equals `miss_addr[31:5]`.
- R6: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. It is then low until the response for that request is taken. Only one word is outstanding at a time.
- R7: A miss is accepted only when `miss_ready` is 1. `miss_valid` asserted during a refill does not change the requested addresses or start a second refill.
- R8: After reset, `miss_ready`=1, and `mem_req_valid`, `cpu_valid` and `line_wr_valid` are 0.
- R9: `mem_req_addr` equals the line base `{miss_addr[31:5], 5'b0}` plus 4 times the word index. Its two low bits are always zero.
- R10: `miss_wrap` is sampled only at acceptance. Changing it during a refill does not alter the fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss presented |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_wrap | input | 1 | 1 = wrapping critical-word-first order, 0 = natural order |
| miss_ready | output | 1 | Unit idle, miss will be accepted |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_data | input | 32 | Returned word |
| cpu_valid | output | 1 | Missed word delivered to the processor |
| cpu_data | output | 32 | Missed word |
| line_wr_valid | output | 1 | Full line write to the data array |
| line_wr_addr | output | 27 | Line address |
| line_wr_data | output | 256 | Line contents, word i at bits 32*i+31:32*i |

## Verification
Random refills use random addresses, both modes and random memory stalls on both request and response. They show whether the fetch order follows the mode latched at acceptance and whether the forward lands on the right response. Directed refills at word 0 and word 7 in both modes cover the corners. In wrapping mode, k=0 and natural order give the same order, which tells apart a wrap error from an offset error. Natural order with k=7 pins the forward to the final response. Stimulus that changes the mode and raises a second miss during a refill shows whether inputs leak into an active refill.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int unsigned LINE_WORDS = 8;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned ADDR_BITS  = 32;

  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_WAIT = 2'd2,
    RF_DONE = 2'd3
  } refill_state_e;
endpackage

// File: rtl/refill_order.sv
module refill_order #(
  parameter int unsigned WORDS = refill_pkg::LINE_WORDS,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic [IW-1:0] step,
  input  logic [IW-1:0] crit,
  input  logic          wrap,
  output logic [IW-1:0] word_idx
);
  // Fetch position -> word index; modulo comes from IW-bit truncation.
  function automatic logic [IW-1:0] pick_word(input logic [IW-1:0] n,
                                              input logic [IW-1:0] k,
                                              input logic          w);
    logic [IW-1:0] s;
    s = n + k;
    return w ? s : n;
  endfunction

  assign word_idx = pick_word(step, crit, wrap);
endmodule

// File: rtl/refill_line_buf.sv
module refill_line_buf #(
  parameter int unsigned WORDS = refill_pkg::LINE_WORDS,
  parameter int unsigned DW    = refill_pkg::WORD_BITS,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [WORDS*DW-1:0] line
);
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= '0;
      else if (wr_en && wr_idx == IW'(g))
        slot_q <= wr_data;
    end
    assign line[g*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int unsigned WORDS = refill_pkg::LINE_WORDS,
  parameter int unsigned LW    = 27,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [IW-1:0] miss_word,
  input  logic [LW-1:0] miss_line,
  input  logic          miss_wrap,
  input  logic          req_ready,
  input  logic          rsp_valid,
  output logic          idle,
  output logic          accept,
  output logic          req_valid,
  output logic          rsp_take,
  output logic          done,
  output logic [IW-1:0] step_q,
  output logic [IW-1:0] crit_q,
  output logic          wrap_q,
  output logic [LW-1:0] line_q
);
  import refill_pkg::*;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  refill_state_e st_q;

  assign idle      = (st_q == RF_IDLE);
  assign accept    = idle && miss_valid;
  assign req_valid = (st_q == RF_REQ);
  assign rsp_take  = (st_q == RF_WAIT) && rsp_valid;
  assign done      = (st_q == RF_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RF_IDLE;
      step_q <= '0;
      crit_q <= '0;
      wrap_q <= 1'b0;
      line_q <= '0;
    end else begin
      unique case (st_q)
        RF_IDLE: if (miss_valid) begin
          st_q   <= RF_REQ;
          step_q <= '0;
          crit_q <= miss_word;
          wrap_q <= miss_wrap;
          line_q <= miss_line;
        end
        RF_REQ:  if (req_ready) st_q <= RF_WAIT;
        RF_WAIT: if (rsp_valid) begin
          if (step_q == LAST) st_q <= RF_DONE;
          else begin
            step_q <= step_q + 1'b1;
            st_q   <= RF_REQ;
          end
        end
        RF_DONE: st_q <= RF_IDLE;
        default: st_q <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_refill_unit.sv
module line_refill_unit #(
  parameter int unsigned WORDS = refill_pkg::LINE_WORDS,
  parameter int unsigned DW    = refill_pkg::WORD_BITS,
  parameter int unsigned AW    = refill_pkg::ADDR_BITS,
  localparam int unsigned IW = $clog2(WORDS),
  localparam int unsigned BW = $clog2(DW / 8),
  localparam int unsigned LW = AW - IW - BW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_valid,
  input  logic [AW-1:0]       miss_addr,
  input  logic                miss_wrap,
  output logic                miss_ready,
  output logic                mem_req_valid,
  output logic [AW-1:0]       mem_req_addr,
  input  logic                mem_req_ready,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data,
  output logic                cpu_valid,
  output logic [DW-1:0]       cpu_data,
  output logic                line_wr_valid,
  output logic [LW-1:0]       line_wr_addr,
  output logic [WORDS*DW-1:0] line_wr_data
);
  logic          miss_accept;
  logic          rsp_take;
  logic          fwd_evt;
  logic          line_done;
  logic [IW-1:0] step_q, crit_q, word_idx;
  logic          wrap_q;
  logic [LW-1:0] line_q;

  refill_ctrl #(.WORDS(WORDS), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid),
    .miss_word(miss_addr[BW +: IW]),
    .miss_line(miss_addr[AW-1 -: LW]),
    .miss_wrap(miss_wrap),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .idle(miss_ready),
    .accept(miss_accept),
    .req_valid(mem_req_valid),
    .rsp_take(rsp_take),
    .done(line_done),
    .step_q(step_q), .crit_q(crit_q), .wrap_q(wrap_q), .line_q(line_q)
  );

  refill_order #(.WORDS(WORDS)) u_order (
    .step(step_q), .crit(crit_q), .wrap(wrap_q), .word_idx(word_idx)
  );

  refill_line_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rsp_take), .wr_idx(word_idx), .wr_data(mem_rsp_data),
    .line(line_wr_data)
  );

  assign mem_req_addr  = {line_q, word_idx, {BW{1'b0}}};
  assign fwd_evt       = rsp_take && (word_idx == crit_q);
  assign cpu_valid     = fwd_evt;
  assign cpu_data      = mem_rsp_data;
  assign line_wr_valid = line_done;
  assign line_wr_addr  = line_q;
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int unsigned WORDS = refill_pkg::LINE_WORDS,
  parameter int unsigned AW    = refill_pkg::ADDR_BITS,
  localparam int unsigned IW = $clog2(WORDS),
  localparam int unsigned CW = IW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_accept,
  input logic [AW-1:0] miss_addr,
  input logic          miss_wrap,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          rsp_take,
  input logic          fwd_evt,
  input logic          line_done
);
  logic [CW-1:0] fwd_cnt, rsp_cnt;
  logic          first_q, wrap_l;
  logic [IW-1:0] k_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_cnt <= '0; rsp_cnt <= '0; first_q <= 1'b0; wrap_l <= 1'b0; k_l <= '0;
    end else if (miss_accept) begin
      fwd_cnt <= '0; rsp_cnt <= '0; first_q <= 1'b1;
      wrap_l  <= miss_wrap; k_l <= miss_addr[2 +: IW];
    end else begin
      if (fwd_evt)  fwd_cnt <= fwd_cnt + 1'b1;
      if (rsp_take) rsp_cnt <= rsp_cnt + 1'b1;
      if (mem_req_valid && mem_req_ready) first_q <= 1'b0;
    end
  end

  // R1: wrapping mode asks for the missed word first
  a_r1_first_is_crit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && first_q && wrap_l) |-> mem_req_addr[2 +: IW] == k_l);
  // R2: natural order starts at word 0
  a_r2_first_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && first_q && !wrap_l) |-> mem_req_addr[2 +: IW] == '0);
  // R4: one forward per refill
  a_r4_one_forward: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> fwd_cnt == CW'(1));
  // R5: line written only with every word in
  a_r5_full_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> rsp_cnt == CW'(WORDS));
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  // R6: request held until taken
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  // R7: an accepted miss launches a request next cycle
  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    miss_accept |=> mem_req_valid);
  // R9: word aligned requests
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
endmodule

bind line_refill_unit refill_checker #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .miss_accept(miss_accept), .miss_addr(miss_addr), .miss_wrap(miss_wrap),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_take(rsp_take), .fwd_evt(fwd_evt),
  .line_done(line_done)
);

// File: tb/sim_line_refill_unit.sv
`timescale 1ns/1ps
module sim_line_refill_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = '0;
  logic         miss_wrap = 1'b0;
  logic         miss_ready;
  logic         mem_req_valid;
  logic [31:0]  mem_req_addr;
  logic         mem_req_ready = 1'b0;
  logic         mem_rsp_valid = 1'b0;
  logic [31:0]  mem_rsp_data = '0;
  logic         cpu_valid;
  logic [31:0]  cpu_data;
  logic         line_wr_valid;
  logic [26:0]  line_wr_addr;
  logic [255:0] line_wr_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  line_refill_unit u0 (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_word(input int n, input int k, input bit w);
    return w ? ((k + n) % 8) : n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [31:0] addr, input bit wrap, input bit poke);
    int k, fwd_seen, fwd_pos;
    logic [31:0] base;
    logic [255:0] line_exp;
    k = int'(addr[4:2]);
    base = {addr[31:5], 5'b0};
    fwd_seen = 0; fwd_pos = -1;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R7 idle before miss", 256'(miss_ready), 256'(1));
    miss_addr = addr; miss_wrap = wrap; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = poke;
    miss_addr  = addr ^ 32'h0000_0FFC;
    miss_wrap  = ~wrap;                      // R10: changed mid refill
    chk(miss_ready == 1'b0, "R7 busy after accept", 256'(miss_ready), 256'(0));
    for (int n = 0; n < 8; n++) begin
      automatic logic [31:0] ea = base + 32'(4 * exp_word(n, k, wrap));
      automatic int stall = int'($urandom_range(0, 2));
      automatic int dly   = int'($urandom_range(0, 3));
      chk(mem_req_valid == 1'b1, "R6 request raised", 256'(mem_req_valid), 256'(1));
      chk(mem_req_addr == ea, wrap ? "R1 R9 R10 wrap order" : "R2 R9 R10 natural order",
          256'(mem_req_addr), 256'(ea));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea, "R6 request held",
            256'(mem_req_addr), 256'(ea));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int d = 0; d < dly; d++) begin
        chk(mem_req_valid == 1'b0, "R6 one outstanding", 256'(mem_req_valid), 256'(0));
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(ea);
      #1;
      if (exp_word(n, k, wrap) == k) begin
        chk(cpu_valid == 1'b1 && cpu_data == mem_word(ea), "R3 forward on arrival",
            256'(cpu_data), 256'(mem_word(ea)));
      end else begin
        chk(cpu_valid == 1'b0, "R3 no forward for other words", 256'(cpu_valid), 256'(0));
      end
      if (cpu_valid) begin fwd_seen++; fwd_pos = n; end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    miss_valid = 1'b0;
    chk(fwd_seen == 1, "R4 one forward", 256'(fwd_seen), 256'(1));
    chk(fwd_pos == (wrap ? 0 : k), "R4 forward position", 256'(fwd_pos),
        256'(wrap ? 0 : k));
    line_exp = '0;
    for (int i = 0; i < 8; i++) line_exp[32*i +: 32] = mem_word(base + 32'(4 * i));
    chk(line_wr_valid == 1'b1, "R5 line write", 256'(line_wr_valid), 256'(1));
    chk(line_wr_data == line_exp, "R5 line data", line_wr_data, line_exp);
    chk(line_wr_addr == addr[31:5], "R5 line addr", 256'(line_wr_addr), 256'(addr[31:5]));
    @(negedge clk);
    chk(line_wr_valid == 1'b0, "R5 single cycle", 256'(line_wr_valid), 256'(0));
    chk(miss_ready && !mem_req_valid, "R7 no second refill from poke",
        256'({miss_ready, mem_req_valid}), 256'(2'b10));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(miss_ready == 1'b1, "R8 ready", 256'(miss_ready), 256'(1));
    chk(!mem_req_valid && !cpu_valid && !line_wr_valid, "R8 outputs low",
        256'({mem_req_valid, cpu_valid, line_wr_valid}), 256'(0));
    rst_n = 1'b1;
    refill(32'h1000_0000, 1'b1, 1'b0);   // wrap, k=0
    refill(32'h1000_003C, 1'b1, 1'b1);   // wrap, k=7
    refill(32'h2000_0040, 1'b0, 1'b0);   // natural, k=0
    refill(32'h2000_007C, 1'b0, 1'b1);   // natural, k=7 (no gain)
    refill(32'h3000_0094, 1'b1, 1'b1);   // wrap, k=5
    for (int t = 0; t < 40; t++)
      refill({$urandom} & 32'hFFFF_FFFC, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule